// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block gives a host processor with a 32-bit memory-mapped register port a path into a small 8-bit register space that lives behind a slow back-end bus. The host does not address the back-end registers directly. It programs a control word that names the target byte register, the direction and the byte enables. A read starts as soon as a read-direction control word lands. A write is armed by a write-direction control word and starts only when the host then writes the lower data register. The bridge drives the back-end strobes for a fixed number of cycles and raises a busy bit in the control word for that whole window. A read returns its byte in the lower data register once busy drops.

The host port is a plain single-cycle register port with combinational read data and no back-pressure. The busy bit is the only flow control. While busy is set, the bridge silently drops host writes to the control and lower data registers, so software polls busy between steps. The bridge also collects two interrupt sources into a flag register with write-one-to-clear bits, and masks them with an enable register onto one interrupt line. One source is a transfer-complete event from the bridge itself. The other is a level input from the subsystem.

Top module: `idxb_bridge`

## Requirements
- R1: After reset, the control, lower data, upper data, interrupt enable and interrupt flag registers all read 0, and `irq_out` is 0. Offset 0x00 reads the `ID_VALUE` parameter.
- R2: The control register (offset 0x04) reads back as follows: bit 31 is busy, bit 25 is size, bit 24 is direction, bits 23:20 are the upper byte enables, bits 19:16 are the lower byte enables, and bits 7:0 are the target address. All other bits read 0.
- R3: Writing the control register while idle with bit 24 = 1 starts a read. Busy reads 1 for exactly `XFER_CYC` cycles, beginning in the cycle after the write. For all of those cycles, `be_rd` is high and `be_addr` holds control bits 7:0.
- R4: At the end of a read, the lower data register (offset 0x08) holds the `be_rdata` byte sampled in the final busy cycle, in bits 7:0, with bits 31:8 zero.
- R5: Writing the control register while idle with bit 24 = 0 only arms a write and leaves busy at 0. The next idle write to the lower data register starts the transfer. For `XFER_CYC` cycles, `be_wdata` is data bits 7:0, `be_addr` is control bits 7:0, and `be_wr` is high provided control bit 16 is 1.
- R6: An armed write whose control bit 16 is 0 still runs busy for `XFER_CYC` cycles, but it never raises `be_wr`.
- R7: A lower data write when no write is armed only stores the value. No transfer starts.
- R8: While busy, host writes to the control and lower data registers are ignored.
- R9: The upper data register (offset 0x0C) is plain 32-bit read/write storage.
- R10: Flag register (offset 0x14) bit 0 is set by every transfer completion. Bit 1 is set in each cycle that `sub_irq` is high. Writing 1 to a flag bit clears it, and a set in the same cycle wins.
- R11: `irq_out` is high exactly when some flag bit is 1 and the matching bit of the enable register (offset 0x10, bits 1:0) is 1.
- R12: `be_rd` and `be_wr` are never high together, and neither is high while busy is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hst_en | input | 1 | Host access strobe |
| hst_we | input | 1 | Host write (1) or read (0) |
| hst_addr | input | 5 | Host byte offset |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Host read data, combinational from `hst_addr` |
| be_addr | output | 8 | Back-end register address |
| be_wdata | output | 8 | Back-end write byte |
| be_wr | output | 1 | Back-end write strobe |
| be_rd | output | 1 | Back-end read strobe |
| be_rdata | input | 8 | Back-end read byte |
| sub_irq | input | 1 | Subsystem interrupt level |
| irq_out | output | 1 | Masked interrupt line |

## Verification
Reads are swept over all 256 back-end addresses against a back end whose data is an arithmetic function of the address. This separates address routing faults from capture timing faults. Writes are swept over all addresses with a data byte that differs per address, so a mix-up between address and data shows up. Separate patterns cover an armed write with its byte enable clear, a lower data write with nothing armed, and writes issued during busy, which tell the write trigger apart from ignore-while-busy. The interrupt sequence toggles each enable and flag bit on its own, which exposes a mask or clear applied to the wrong bit.

// File: rtl/idxb_pkg.sv
package idxb_pkg;
  localparam int HOST_AW = 5;
  localparam int BYTE_W  = 8;
  localparam int WORD_W  = 32;

  localparam logic [HOST_AW-1:0] OFS_ID  = 5'h00;
  localparam logic [HOST_AW-1:0] OFS_CTL = 5'h04;
  localparam logic [HOST_AW-1:0] OFS_LD  = 5'h08;
  localparam logic [HOST_AW-1:0] OFS_UD  = 5'h0C;
  localparam logic [HOST_AW-1:0] OFS_EN  = 5'h10;
  localparam logic [HOST_AW-1:0] OFS_FLG = 5'h14;

  localparam int BIT_BUSY = 31;
  localparam int BIT_SIZE = 25;
  localparam int BIT_DIR  = 24;
  localparam int LSB_BENH = 20;
  localparam int LSB_BENL = 16;

  localparam int NUM_IRQ = 2;

  typedef struct packed {
    logic              size;
    logic              dir;
    logic [3:0]        ben_hi;
    logic [3:0]        ben_lo;
    logic [BYTE_W-1:0] addr;
  } ctl_t;
endpackage

// File: rtl/idxb_regs.sv
module idxb_regs
  import idxb_pkg::*;
#(
  parameter logic [WORD_W-1:0] ID_VALUE = 32'h1D0B_0001
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hst_en,
  input  logic                hst_we,
  input  logic [HOST_AW-1:0]  hst_addr,
  input  logic [WORD_W-1:0]   hst_wdata,
  output logic [WORD_W-1:0]   hst_rdata,
  input  logic                busy,
  input  logic                cap_en,
  input  logic [BYTE_W-1:0]   cap_byte,
  input  logic [NUM_IRQ-1:0]  flg,
  input  logic [NUM_IRQ-1:0]  ien,
  output ctl_t                ctl,
  output logic [WORD_W-1:0]   ldata,
  output logic                start_rd,
  output logic                start_wr,
  output logic                wr_en_reg,
  output logic                wr_flg_reg
);
  logic        host_wr;
  logic        wr_ctl, wr_ld, wr_ud;
  logic        armed;
  logic [WORD_W-1:0] udata;

  assign host_wr    = hst_en & hst_we;
  assign wr_ctl     = host_wr & (hst_addr == OFS_CTL) & ~busy;
  assign wr_ld      = host_wr & (hst_addr == OFS_LD)  & ~busy;
  assign wr_ud      = host_wr & (hst_addr == OFS_UD);
  assign wr_en_reg  = host_wr & (hst_addr == OFS_EN);
  assign wr_flg_reg = host_wr & (hst_addr == OFS_FLG);

  assign start_rd = wr_ctl & hst_wdata[BIT_DIR];
  assign start_wr = wr_ld & armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl <= '0;
    end else if (wr_ctl) begin
      ctl.size   <= hst_wdata[BIT_SIZE];
      ctl.dir    <= hst_wdata[BIT_DIR];
      ctl.ben_hi <= hst_wdata[LSB_BENH +: 4];
      ctl.ben_lo <= hst_wdata[LSB_BENL +: 4];
      ctl.addr   <= hst_wdata[BYTE_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
    end else if (wr_ctl) begin
      armed <= ~hst_wdata[BIT_DIR];
    end else if (start_wr) begin
      armed <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ldata <= '0;
    end else if (cap_en) begin
      ldata <= {{(WORD_W-BYTE_W){1'b0}}, cap_byte};
    end else if (wr_ld) begin
      ldata <= hst_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      udata <= '0;
    end else if (wr_ud) begin
      udata <= hst_wdata;
    end
  end

  always_comb begin
    hst_rdata = '0;
    unique case (hst_addr)
      OFS_ID:  hst_rdata = ID_VALUE;
      OFS_CTL: begin
        hst_rdata[BIT_BUSY]           = busy;
        hst_rdata[BIT_SIZE]           = ctl.size;
        hst_rdata[BIT_DIR]            = ctl.dir;
        hst_rdata[LSB_BENH +: 4]      = ctl.ben_hi;
        hst_rdata[LSB_BENL +: 4]      = ctl.ben_lo;
        hst_rdata[BYTE_W-1:0]         = ctl.addr;
      end
      OFS_LD:  hst_rdata = ldata;
      OFS_UD:  hst_rdata = udata;
      OFS_EN:  hst_rdata[NUM_IRQ-1:0] = ien;
      OFS_FLG: hst_rdata[NUM_IRQ-1:0] = flg;
      default: hst_rdata = '0;
    endcase
  end
endmodule

// File: rtl/idxb_seq.sv
module idxb_seq
  import idxb_pkg::*;
#(
  parameter int XFER_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_rd,
  input  logic              start_wr,
  input  logic              strobe_ok,
  input  logic [BYTE_W-1:0] be_rdata,
  output logic              busy,
  output logic              be_rd,
  output logic              be_wr,
  output logic              cap_en,
  output logic [BYTE_W-1:0] cap_byte,
  output logic              done
);
  localparam int CNT_W = (XFER_CYC > 2) ? $clog2(XFER_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(XFER_CYC - 1);

  logic [CNT_W-1:0] cnt;
  logic             op_rd;
  logic             op_strb;
  logic             last;

  assign last = busy & (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      cnt     <= '0;
      op_rd   <= 1'b0;
      op_strb <= 1'b0;
    end else if (!busy && (start_rd || start_wr)) begin
      busy    <= 1'b1;
      cnt     <= CNT_LOAD;
      op_rd   <= start_rd;
      op_strb <= start_rd | strobe_ok;
    end else if (busy) begin
      if (last) begin
        busy <= 1'b0;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  assign be_rd    = busy & op_rd;
  assign be_wr    = busy & ~op_rd & op_strb;
  assign cap_en   = last & op_rd;
  assign cap_byte = be_rdata;
  assign done     = last;
endmodule

// File: rtl/idxb_irq.sv
module idxb_irq
  import idxb_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sub_irq,
  input  logic               done,
  input  logic               wr_en_reg,
  input  logic               wr_flg_reg,
  input  logic [NUM_IRQ-1:0] wbits,
  output logic [NUM_IRQ-1:0] flg,
  output logic [NUM_IRQ-1:0] ien,
  output logic               irq_out
);
  logic [NUM_IRQ-1:0] set_vec;
  logic [NUM_IRQ-1:0] clr_vec;

  assign set_vec = {sub_irq, done};
  assign clr_vec = wr_flg_reg ? wbits : '0;

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flg[i] <= 1'b0;
      end else if (set_vec[i]) begin
        flg[i] <= 1'b1;
      end else if (clr_vec[i]) begin
        flg[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien <= '0;
    end else if (wr_en_reg) begin
      ien <= wbits;
    end
  end

  assign irq_out = |(flg & ien);
endmodule

// File: rtl/idxb_bridge.sv
module idxb_bridge
  import idxb_pkg::*;
#(
  parameter int                XFER_CYC = 4,
  parameter logic [31:0]       ID_VALUE = 32'h1D0B_0001
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        hst_en,
  input  logic        hst_we,
  input  logic [4:0]  hst_addr,
  input  logic [31:0] hst_wdata,
  output logic [31:0] hst_rdata,
  output logic [7:0]  be_addr,
  output logic [7:0]  be_wdata,
  output logic        be_wr,
  output logic        be_rd,
  input  logic [7:0]  be_rdata,
  input  logic        sub_irq,
  output logic        irq_out
);
  ctl_t               ctl;
  logic [WORD_W-1:0]  ldata;
  logic               busy;
  logic               start_rd, start_wr;
  logic               cap_en, done;
  logic [BYTE_W-1:0]  cap_byte;
  logic               wr_en_reg, wr_flg_reg;
  logic [NUM_IRQ-1:0] int_flg, int_en;

  idxb_regs #(.ID_VALUE(ID_VALUE)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .hst_en(hst_en), .hst_we(hst_we), .hst_addr(hst_addr),
    .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
    .busy(busy), .cap_en(cap_en), .cap_byte(cap_byte),
    .flg(int_flg), .ien(int_en),
    .ctl(ctl), .ldata(ldata),
    .start_rd(start_rd), .start_wr(start_wr),
    .wr_en_reg(wr_en_reg), .wr_flg_reg(wr_flg_reg)
  );

  idxb_seq #(.XFER_CYC(XFER_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .start_rd(start_rd), .start_wr(start_wr),
    .strobe_ok(ctl.ben_lo[0]), .be_rdata(be_rdata),
    .busy(busy), .be_rd(be_rd), .be_wr(be_wr),
    .cap_en(cap_en), .cap_byte(cap_byte), .done(done)
  );

  idxb_irq u_irq (
    .clk(clk), .rst_n(rst_n),
    .sub_irq(sub_irq), .done(done),
    .wr_en_reg(wr_en_reg), .wr_flg_reg(wr_flg_reg),
    .wbits(hst_wdata[NUM_IRQ-1:0]),
    .flg(int_flg), .ien(int_en), .irq_out(irq_out)
  );

  assign be_addr  = ctl.addr;
  assign be_wdata = ldata[BYTE_W-1:0];
endmodule

// File: rtl/idxb_chk.sv
module idxb_chk #(
  parameter int XFER_CYC = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       hst_en,
  input logic       hst_we,
  input logic       busy,
  input logic       be_rd,
  input logic       be_wr,
  input logic [7:0] be_addr,
  input logic       sub_irq,
  input logic [1:0] flg
);
  logic [15:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run <= '0;
    else        run <= busy ? run + 16'd1 : 16'd0;
  end

  assert_strobe_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(be_rd && be_wr));

  assert_strobe_in_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (be_rd || be_wr) |-> busy);

  assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(be_addr));

  assert_busy_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run == 16'(XFER_CYC)));

  assert_start_by_host_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(hst_en && hst_we));

  assert_sub_latch_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sub_irq |=> flg[1]);
endmodule

bind idxb_bridge idxb_chk #(.XFER_CYC(XFER_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .hst_en(hst_en), .hst_we(hst_we),
  .busy(busy), .be_rd(be_rd), .be_wr(be_wr), .be_addr(be_addr),
  .sub_irq(sub_irq), .flg(int_flg)
);

// File: tb/idxb_bridge_test.sv
module idxb_bridge_test;
  localparam int          XC  = 3;
  localparam logic [31:0] IDV = 32'h1D0B_0001;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hst_en = 1'b0, hst_we = 1'b0;
  logic [4:0]  hst_addr = '0;
  logic [31:0] hst_wdata = '0;
  logic [31:0] hst_rdata;
  logic [7:0]  be_addr, be_wdata, be_rdata;
  logic        be_wr, be_rd, irq_out;
  logic        sub_irq = 1'b0;

  int n_chk = 0, n_bad = 0;
  int rd_cyc = 0, wr_cyc = 0;
  logic [7:0] last_ra = '0, last_wa = '0, last_wd = '0;

  always #5 clk = ~clk;

  assign be_rdata = be_addr ^ 8'h5A;

  idxb_bridge #(.XFER_CYC(XC), .ID_VALUE(IDV)) uut (
    .clk(clk), .rst_n(rst_n), .hst_en(hst_en), .hst_we(hst_we),
    .hst_addr(hst_addr), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
    .be_addr(be_addr), .be_wdata(be_wdata), .be_wr(be_wr), .be_rd(be_rd),
    .be_rdata(be_rdata), .sub_irq(sub_irq), .irq_out(irq_out)
  );

  always @(posedge clk) begin
    if (be_rd) begin rd_cyc <= rd_cyc + 1; last_ra <= be_addr; end
    if (be_wr) begin wr_cyc <= wr_cyc + 1; last_wa <= be_addr; last_wd <= be_wdata; end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    hst_en = 1'b1; hst_we = 1'b1; hst_addr = a; hst_wdata = d;
    @(posedge clk); #1;
    hst_en = 1'b0; hst_we = 1'b0;
  endtask

  task automatic hread(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    hst_addr = a;
    #1 d = hst_rdata;
  endtask

  task automatic wait_idle(output int n);
    logic [31:0] v;
    n = 0;
    hread(5'h04, v);
    while (v[31]) begin
      n++;
      hread(5'h04, v);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int n, r0, w0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset values
    hread(5'h00, v); chk("R1 id", v, IDV);
    hread(5'h04, v); chk("R1 ctl", v, 0);
    hread(5'h08, v); chk("R1 ldata", v, 0);
    hread(5'h0C, v); chk("R1 udata", v, 0);
    hread(5'h10, v); chk("R1 enable", v, 0);
    hread(5'h14, v); chk("R1 flags", v, 0);
    chk("R1 irq", {31'b0, irq_out}, 0);

    // R3 R4 read sweep over every address
    for (int a = 0; a < 256; a++) begin
      r0 = rd_cyc;
      hwrite(5'h04, 32'h0101_0000 | a);
      wait_idle(n);
      if (a < 4 || a == 255) begin
        chk("R3 busy cycles", n, XC);
        chk("R3 be_rd cycles", rd_cyc - r0, XC);
        chk("R3 be_addr", {24'b0, last_ra}, a);
      end
      hread(5'h08, v); chk("R4 read byte", v, (a ^ 8'h5A) & 8'hFF);
    end

    // R5 write sweep
    for (int a = 0; a < 256; a++) begin
      w0 = wr_cyc;
      hwrite(5'h04, 32'h0001_0000 | a);
      if (a == 0) begin
        hread(5'h04, v); chk("R5 armed not busy", {31'b0, v[31]}, 0);
      end
      hwrite(5'h08, 32'hABCD_EF00 | ((a * 37 + 11) & 8'hFF));
      wait_idle(n);
      chk("R5 write addr", {24'b0, last_wa}, a);
      chk("R5 write data", {24'b0, last_wd}, (a * 37 + 11) & 8'hFF);
      if (a < 4) chk("R5 be_wr cycles", wr_cyc - w0, XC);
    end

    // R6 byte enable clear
    w0 = wr_cyc;
    hwrite(5'h04, 32'h0000_0033);
    hwrite(5'h08, 32'h0000_0077);
    wait_idle(n);
    chk("R6 busy cycles", n, XC);
    chk("R6 no strobe", wr_cyc - w0, 0);

    // R7 data write with nothing armed
    w0 = wr_cyc;
    hwrite(5'h08, 32'h1234_5678);
    hread(5'h04, v); chk("R7 no busy", {31'b0, v[31]}, 0);
    hread(5'h08, v); chk("R7 stored", v, 32'h1234_5678);
    chk("R7 no strobe", wr_cyc - w0, 0);

    // R8 writes during busy ignored
    w0 = wr_cyc; r0 = rd_cyc;
    hwrite(5'h04, 32'h0001_0044);
    hwrite(5'h08, 32'h0000_0099);
    hwrite(5'h04, 32'h0100_0077);
    hwrite(5'h08, 32'h0000_00EE);
    wait_idle(n);
    hread(5'h04, v); chk("R8 ctl kept", v, 32'h0001_0044);
    hread(5'h08, v); chk("R8 ldata kept", v, 32'h0000_0099);
    chk("R8 wrote first byte", {24'b0, last_wd}, 8'h99);
    chk("R8 no read started", rd_cyc - r0, 0);
    chk("R8 one transfer", wr_cyc - w0, XC);

    // R9 upper data
    hwrite(5'h0C, 32'hCAFE_F00D);
    hread(5'h0C, v); chk("R9 udata", v, 32'hCAFE_F00D);

    // R2 control layout
    hwrite(5'h04, 32'hFFFF_FFFF);
    hread(5'h04, v); chk("R2 busy bit", {31'b0, v[31]}, 1);
    wait_idle(n);
    hread(5'h04, v); chk("R2 layout", v, 32'h03FF_00FF);
    hread(5'h08, v); chk("R4 addr ff", v, 32'h0000_00A5);

    // R10 R11 interrupts
    hwrite(5'h14, 32'h3);
    hread(5'h14, v); chk("R10 cleared", v, 0);
    hwrite(5'h04, 32'h0101_0010);
    wait_idle(n);
    hread(5'h14, v); chk("R10 done flag", v, 1);
    chk("R11 masked", {31'b0, irq_out}, 0);
    hwrite(5'h10, 32'h1);
    hread(5'h10, v); chk("R11 enable reg", v, 1);
    chk("R11 irq on", {31'b0, irq_out}, 1);
    hwrite(5'h14, 32'h1);
    hread(5'h14, v); chk("R10 w1c bit0", v, 0);
    chk("R11 irq off", {31'b0, irq_out}, 0);
    @(negedge clk); sub_irq = 1'b1;
    @(negedge clk); sub_irq = 1'b0;
    hread(5'h14, v); chk("R10 sub flag", v, 2);
    chk("R11 bit1 masked", {31'b0, irq_out}, 0);
    hwrite(5'h10, 32'h2);
    hread(5'h14, v); chk("R11 bit1 on", {31'b0, irq_out}, 1);
    hwrite(5'h14, 32'h1);
    hread(5'h14, v); chk("R10 w1c other bit", v, 2);
    @(negedge clk); sub_irq = 1'b1; hst_en = 1'b1; hst_we = 1'b1;
    hst_addr = 5'h14; hst_wdata = 32'h2;
    @(negedge clk); sub_irq = 1'b0; hst_en = 1'b0; hst_we = 1'b0;
    hread(5'h14, v); chk("R10 set wins", v, 2);
    hwrite(5'h14, 32'h2);
    hread(5'h14, v); chk("R10 w1c bit1", v, 0);
    chk("R12 strobes idle", {30'b0, be_rd, be_wr}, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule